// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing part of a simple serial port. A host reaches it through a word-addressed register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. Characters come in from a byte-stream source that has a valid, a ready and a break marker. The block holds one incoming character at a time. Outgoing characters leave on a byte stream as a single-cycle valid pulse. A single level interrupt combines the receive-ready condition with the transmit-ready condition.

The host configures the port through three control registers, a FIFO-control shadow, baud count and modulator shadows, and a one-millisecond shadow. It learns the port's state from two status registers and a test register. Reading the receive-data word hands the buffered character over and marks it consumed in the same access. Writing control register 2 with its bit 0 low restores the reset state. Bit-level serialisation and baud generation sit outside this block.

Top module: `sio_reg_front`

## Requirements
- R1: After the synchronous reset, the registers read back as follows. Control1 0x0000, control2 0x0001, control3 0x0700, FIFO control 0x0000, status1 0x6040, status2 0x4028, modulator 0x0000, baud count 0x0004, one-ms 0x0000, test 0x0060, receive data 0x4000. In that state the interrupt is low and `rx_ready` is high.
- R2: The word offsets are control1 0x20, control2 0x21, control3 0x22, FIFO control 0x24, status1 0x25, status2 0x26, modulator 0x2A, baud count 0x2B, one-ms 0x2C, test 0x2D and receive data 0x00. The control, FIFO, modulator, baud-count and one-ms words store a write and read it back. Offsets 0x23, 0x29 and every other unlisted offset read 0, and writes to them, to 0x2D and to 0x00 change nothing.
- R3: `rx_ready` is the inverse of status1 bit 9. A character is taken on a cycle with `rx_valid` and `rx_ready` both high. Taking it stores the character zero-extended, sets status1 bit 9 and status2 bit 0, and clears test bit 5. While the buffer is full, offered characters are not taken.
- R4: `bus_rdata` always shows the addressed register. A read strobe at offset 0x00 while the buffer is full returns the buffered word with bit 15 set. That access also clears status1 bit 9 and status2 bit 0 and sets test bit 5 at the next edge. When the buffer is empty the same read returns the word without bit 15 and changes nothing.
- R5: A character taken with `rx_brk` high is stored as 0x0800, whatever `rx_data` holds.
- R6: A write to status1 clears the bits in mask 0x9DB0 that are written as 1. A write to status2 does the same with mask 0xBDD6. No other status bit changes on a status write, so writing all-ones leaves the status reset values and the receive-ready bits intact.
- R7: A write to offset 0x10 while control2 bit 2 is set makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written low byte. When control2 bit 2 is clear, the write produces no pulse.
- R8: `irq` is high exactly when status1 bit 9 and control1 bit 9 are both set, or when status1 bit 13, control1 bit 13 and control1 bit 6 are all set.
- R9: A write to control2 with bit 0 at 0 restores the R1 values of control1, control3, status1, status2, test, modulator, baud count and the receive buffer, and empties the buffer. It leaves FIFO control and one-ms unchanged. Control2 then holds the written value with bit 0 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables receive-data side effect) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| rx_valid | input | 1 | Incoming character offered |
| rx_brk | input | 1 | Offered item is a break |
| rx_data | input | CHAR_W | Incoming character |
| rx_ready | output | 1 | Buffer can take a character |
| tx_valid | output | 1 | Outgoing character pulse |
| tx_data | output | CHAR_W | Outgoing character |
| irq | output | 1 | Level interrupt |

## Verification
Five properties are checked on every clock. Taking a character blocks further ones, and a consuming read shows the valid bit and frees the buffer on the next edge. A transmit write produces its pulse with the written byte, and no pulse appears without such a write. A soft reset leaves control2 bit 0 set and the buffer free, and the interrupt stays low with both enables clear. The unimplemented offsets reading zero is also checked on every cycle. Other points can only be shown by the bench's scenarios comparing all outputs against its reference model every cycle. These are the exact reset and soft-reset values, the preservation of FIFO control and one-ms across a soft reset, the break word, and that all-ones status writes and writes to read-only offsets leave every register unchanged.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int REG_W = 16;
    typedef logic [REG_W-1:0] reg_t;

    // word offsets
    localparam int unsigned OFS_RXD   = 'h00;
    localparam int unsigned OFS_TXD   = 'h10;
    localparam int unsigned OFS_CTL1  = 'h20;
    localparam int unsigned OFS_CTL2  = 'h21;
    localparam int unsigned OFS_CTL3  = 'h22;
    localparam int unsigned OFS_CTL4  = 'h23;
    localparam int unsigned OFS_FIFO  = 'h24;
    localparam int unsigned OFS_STAT1 = 'h25;
    localparam int unsigned OFS_STAT2 = 'h26;
    localparam int unsigned OFS_BINC  = 'h29;
    localparam int unsigned OFS_BMOD  = 'h2A;
    localparam int unsigned OFS_BCNT  = 'h2B;
    localparam int unsigned OFS_MSEC  = 'h2C;
    localparam int unsigned OFS_TEST  = 'h2D;

    // bit positions the behaviour depends on
    localparam int RXD_VALID_BIT = 15;
    localparam int RX_RDY_BIT    = 9;   // status1
    localparam int TX_RDY_BIT    = 13;  // status1
    localparam int DATA_RDY_BIT  = 0;   // status2
    localparam int RX_EMPTY_BIT  = 5;   // test
    localparam int EN_RX_BIT     = 9;   // control1
    localparam int EN_TX_BIT     = 13;  // control1
    localparam int EN_EMPTY_BIT  = 6;   // control1
    localparam int CTL2_NRST_BIT = 0;
    localparam int CTL2_TXEN_BIT = 2;

    // reset and fixed values
    localparam reg_t STAT1_RST  = 16'h6040;
    localparam reg_t STAT2_RST  = 16'h4028;
    localparam reg_t TEST_FIXED = 16'h0040;
    localparam reg_t CTL2_RST   = 16'h0001;
    localparam reg_t CTL3_RST   = 16'h0700;
    localparam reg_t BCNT_RST   = 16'h0004;
    localparam reg_t RXBUF_RST  = 16'h4000;
    localparam reg_t BRK_WORD   = 16'h0800;
    localparam reg_t STAT1_W1C  = 16'h9DB0;
    localparam reg_t STAT2_W1C  = 16'hBDD6;

    typedef struct packed {
        logic rxd;
        logic txd;
        logic ctl1;
        logic ctl2;
        logic ctl3;
        logic fifo;
        logic stat1;
        logic stat2;
        logic bmod;
        logic bcnt;
        logic msec;
        logic test;
    } sel_t;

    function automatic reg_t clear_on_one(reg_t cur, reg_t wval, reg_t mask);
        return cur & ~(wval & mask);
    endfunction

    function automatic reg_t bit_at(logic v, int pos);
        return reg_t'(v) << pos;
    endfunction
endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    always_comb begin
        sel       = '0;
        sel.rxd   = (addr == ADDR_W'(OFS_RXD));
        sel.txd   = (addr == ADDR_W'(OFS_TXD));
        sel.ctl1  = (addr == ADDR_W'(OFS_CTL1));
        sel.ctl2  = (addr == ADDR_W'(OFS_CTL2));
        sel.ctl3  = (addr == ADDR_W'(OFS_CTL3));
        sel.fifo  = (addr == ADDR_W'(OFS_FIFO));
        sel.stat1 = (addr == ADDR_W'(OFS_STAT1));
        sel.stat2 = (addr == ADDR_W'(OFS_STAT2));
        sel.bmod  = (addr == ADDR_W'(OFS_BMOD));
        sel.bcnt  = (addr == ADDR_W'(OFS_BCNT));
        sel.msec  = (addr == ADDR_W'(OFS_MSEC));
        sel.test  = (addr == ADDR_W'(OFS_TEST));
    end
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              in_valid,
    input  logic              in_brk,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              consume,
    output logic              full,
    output reg_t              word
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            full <= 1'b0;
            word <= RXBUF_RST;
        end else if (full) begin
            if (consume) full <= 1'b0;
        end else if (in_valid) begin
            full <= 1'b1;
            word <= in_brk ? BRK_WORD : reg_t'(in_data);
        end
    end
endmodule

// File: rtl/sio_tx_emit.sv
module sio_tx_emit #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [CHAR_W-1:0] byte_in,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= fire;
            if (fire) tx_data <= byte_in;
        end
    end
endmodule

// File: rtl/sio_irq_comb.sv
module sio_irq_comb (
    input  logic rx_rdy,
    input  logic tx_rdy,
    input  logic en_rx,
    input  logic en_tx,
    input  logic en_empty,
    output logic irq
);
    logic rx_src, tx_src;
    always_comb begin
        rx_src = rx_rdy & en_rx;
        tx_src = tx_rdy & en_tx & en_empty;
        irq    = rx_src | tx_src;
    end
endmodule

// File: rtl/sio_reg_front.sv
module sio_reg_front
    import sio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic              rx_brk,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              irq
);
    sel_t sel;
    reg_t ctrl1_q, ctrl2_q, ctrl3_q, fifo_q, bmod_q, bcnt_q, msec_q;
    reg_t stat1_q, stat2_q;
    reg_t rx_word, stat1_rd, stat2_rd, test_rd;
    logic rx_full, soft_rst, tx_fire, consume;

    sio_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign soft_rst = bus_wr && sel.ctl2 && !bus_wdata[CTL2_NRST_BIT];
    assign tx_fire  = bus_wr && sel.txd && ctrl2_q[CTL2_TXEN_BIT];
    assign consume  = bus_rd && sel.rxd;

    sio_rx_hold #(.CHAR_W(CHAR_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .in_valid (rx_valid),
        .in_brk   (rx_brk),
        .in_data  (rx_data),
        .consume  (consume),
        .full     (rx_full),
        .word     (rx_word)
    );

    sio_tx_emit #(.CHAR_W(CHAR_W)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (tx_fire),
        .byte_in  (bus_wdata[CHAR_W-1:0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    assign rx_ready = !rx_full;

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1_q <= '0;
            ctrl2_q <= CTL2_RST;
            ctrl3_q <= CTL3_RST;
            fifo_q  <= '0;
            bmod_q  <= '0;
            bcnt_q  <= BCNT_RST;
            msec_q  <= '0;
            stat1_q <= STAT1_RST;
            stat2_q <= STAT2_RST;
        end else if (soft_rst) begin
            ctrl1_q <= '0;
            ctrl2_q <= bus_wdata | CTL2_RST;
            ctrl3_q <= CTL3_RST;
            bmod_q  <= '0;
            bcnt_q  <= BCNT_RST;
            stat1_q <= STAT1_RST;
            stat2_q <= STAT2_RST;
        end else if (bus_wr) begin
            if (sel.ctl1)  ctrl1_q <= bus_wdata;
            if (sel.ctl2)  ctrl2_q <= bus_wdata;
            if (sel.ctl3)  ctrl3_q <= bus_wdata;
            if (sel.fifo)  fifo_q  <= bus_wdata;
            if (sel.bmod)  bmod_q  <= bus_wdata;
            if (sel.bcnt)  bcnt_q  <= bus_wdata;
            if (sel.msec)  msec_q  <= bus_wdata;
            if (sel.stat1) stat1_q <= clear_on_one(stat1_q, bus_wdata, STAT1_W1C);
            if (sel.stat2) stat2_q <= clear_on_one(stat2_q, bus_wdata, STAT2_W1C);
        end
    end

    // live views of the receive state
    assign stat1_rd = stat1_q | bit_at(rx_full, RX_RDY_BIT);
    assign stat2_rd = stat2_q | bit_at(rx_full, DATA_RDY_BIT);
    assign test_rd  = TEST_FIXED | bit_at(!rx_full, RX_EMPTY_BIT);

    always_comb begin
        bus_rdata = '0;
        if (sel.rxd)   bus_rdata = rx_word | bit_at(rx_full, RXD_VALID_BIT);
        if (sel.ctl1)  bus_rdata = ctrl1_q;
        if (sel.ctl2)  bus_rdata = ctrl2_q;
        if (sel.ctl3)  bus_rdata = ctrl3_q;
        if (sel.fifo)  bus_rdata = fifo_q;
        if (sel.stat1) bus_rdata = stat1_rd;
        if (sel.stat2) bus_rdata = stat2_rd;
        if (sel.bmod)  bus_rdata = bmod_q;
        if (sel.bcnt)  bus_rdata = bcnt_q;
        if (sel.msec)  bus_rdata = msec_q;
        if (sel.test)  bus_rdata = test_rd;
    end

    sio_irq_comb irq_i (
        .rx_rdy   (stat1_rd[RX_RDY_BIT]),
        .tx_rdy   (stat1_rd[TX_RDY_BIT]),
        .en_rx    (ctrl1_q[EN_RX_BIT]),
        .en_tx    (ctrl1_q[EN_TX_BIT]),
        .en_empty (ctrl1_q[EN_EMPTY_BIT]),
        .irq      (irq)
    );
endmodule

// File: rtl/sio_reg_front_chk.sv
module sio_reg_front_chk
    import sio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [CHAR_W-1:0] wr_byte,
    input logic              wr_nrst,
    input logic              valid_bit,
    input logic              rdata_zero,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              irq,
    input logic              en_rx,
    input logic              en_tx,
    input logic              txen,
    input logic              nrst_q
);
    logic soft_w, tx_w, rd_rx, unimpl;
    assign soft_w = bus_wr && bus_addr == ADDR_W'(OFS_CTL2) && !wr_nrst;
    assign tx_w   = bus_wr && bus_addr == ADDR_W'(OFS_TXD) && txen;
    assign rd_rx  = bus_rd && bus_addr == ADDR_W'(OFS_RXD);
    assign unimpl = bus_addr == ADDR_W'(OFS_CTL4) || bus_addr == ADDR_W'(OFS_BINC);

    assert_accept_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && !soft_w) |=> !rx_ready);

    assert_read_shows_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_ready) |-> valid_bit);

    assert_read_frees_buffer_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_ready) |=> rx_ready);

    assert_unimpl_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        unimpl |-> rdata_zero);

    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        tx_w |=> (tx_valid && tx_data == $past(wr_byte)));

    assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_w |=> !tx_valid);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_rx && !en_tx) |-> !irq);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
        soft_w |=> (nrst_q && rx_ready));
endmodule

bind sio_reg_front sio_reg_front_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .wr_byte    (bus_wdata[CHAR_W-1:0]),
    .wr_nrst    (bus_wdata[sio_pkg::CTL2_NRST_BIT]),
    .valid_bit  (bus_rdata[sio_pkg::RXD_VALID_BIT]),
    .rdata_zero (bus_rdata == '0),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .irq        (irq),
    .en_rx      (ctrl1_q[sio_pkg::EN_RX_BIT]),
    .en_tx      (ctrl1_q[sio_pkg::EN_TX_BIT]),
    .txen       (ctrl2_q[sio_pkg::CTL2_TXEN_BIT]),
    .nrst_q     (ctrl2_q[sio_pkg::CTL2_NRST_BIT])
);

// File: tb/sio_reg_front_tb.sv
module sio_reg_front_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx_valid = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_reg_front dut_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .rx_valid(rx_valid),
        .rx_brk(rx_brk), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // behavioural reference state
    bit m_init = 0;
    int m_c1, m_c2, m_c3, m_fc, m_ms, m_bm, m_bc, m_s1, m_s2, m_buf;
    bit m_full, m_txv;
    int m_txd;

    function automatic int exp_rdata(int a);
        case (a)
            'h00: return m_buf | (m_full ? 'h8000 : 0);
            'h20: return m_c1;
            'h21: return m_c2;
            'h22: return m_c3;
            'h24: return m_fc;
            'h25: return m_s1 | (m_full ? 'h0200 : 0);
            'h26: return m_s2 | (m_full ? 'h0001 : 0);
            'h2A: return m_bm;
            'h2B: return m_bc;
            'h2C: return m_ms;
            'h2D: return 'h40 | (m_full ? 0 : 'h20);
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_irq();
        bit tx_rdy = ((m_s1 >> 13) & 1) != 0;
        return (m_full && m_c1[9]) || (tx_rdy && m_c1[13] && m_c1[6]);
    endfunction

    task automatic soft_values();
        m_c1 = 0; m_c3 = 'h700; m_bm = 0; m_bc = 4;
        m_s1 = 'h6040; m_s2 = 'h4028; m_buf = 'h4000; m_full = 0;
    endtask

    task automatic model_update();
        bit nfull;
        int nbuf;
        int w;
        if (rst) begin
            soft_values();
            m_c2 = 1; m_fc = 0; m_ms = 0; m_txv = 0; m_txd = 0;
            m_init = 1;
            return;
        end
        w = int'(wdata);
        nfull = m_full; nbuf = m_buf;
        if (rd && addr == 8'h00 && m_full) nfull = 0;
        if (rx_valid && !m_full) begin
            nfull = 1;
            nbuf = rx_brk ? 'h0800 : int'(rx_data);
        end
        m_txv = wr && addr == 8'h10 && m_c2[2];
        if (m_txv) m_txd = w & 'hFF;
        m_full = nfull; m_buf = nbuf;
        if (wr) begin
            case (addr)
                8'h20: m_c1 = w;
                8'h21: begin
                    if (!w[0]) soft_values();
                    m_c2 = w | 1;
                end
                8'h22: m_c3 = w;
                8'h24: m_fc = w;
                8'h25: m_s1 = m_s1 & ~(w & 'h9DB0);
                8'h26: m_s2 = m_s2 & ~(w & 'hBDD6);
                8'h2A: m_bm = w;
                8'h2B: m_bc = w;
                8'h2C: m_ms = w;
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%02h actual=%04h expected=%04h",
                     tag, what, addr, act, exp);
        end
    endtask

    // one bus cycle: compare outputs mid-cycle, then advance the model
    task automatic step(string tag);
        #1;
        if (m_init) begin
            check(tag, "rdata", int'(rdata), exp_rdata(int'(addr)));
            check(tag, "irq", int'(irq), int'(exp_irq()));
            check(tag, "rx_ready", int'(rx_ready), int'(!m_full));
            check(tag, "tx_valid", int'(tx_valid), int'(m_txv));
            if (m_txv) check(tag, "tx_data", int'(tx_data), m_txd);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic bus_write(string tag, int a, int d);
        addr = 8'(a); wdata = 16'(d); wr = 1'b1;
        step(tag);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(string tag, int a, bit strobe);
        addr = 8'(a); rd = strobe;
        step(tag);
        rd = 1'b0;
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 'h30; a++) bus_read(tag, a, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step("R1"); step("R1");
        rst = 1'b0;
        // R1: reset values on every offset
        sweep("R1");

        // R2: store and read back, read-only and unmapped offsets
        bus_write("R2", 'h20, 'h0011);
        bus_write("R2", 'h22, 'h1234);
        bus_write("R2", 'h24, 'hA5C3);
        bus_write("R2", 'h2A, 'h0F0F);
        bus_write("R2", 'h2B, 'hBEEF);
        bus_write("R2", 'h2C, 'h03E8);
        bus_write("R2", 'h23, 'hFFFF);
        bus_write("R2", 'h29, 'hFFFF);
        bus_write("R2", 'h2D, 'hFFFF);
        bus_write("R2", 'h00, 'hFFFF);
        bus_write("R2", 'h05, 'hFFFF);
        sweep("R2");
        bus_write("R2", 'h20, 'h0000);

        // R6: all-ones to status registers
        bus_write("R6", 'h25, 'hFFFF);
        bus_write("R6", 'h26, 'hFFFF);
        bus_read("R6", 'h25, 1'b0);
        bus_read("R6", 'h26, 1'b0);

        // R4: read of empty receive word has no side effect
        bus_read("R4", 'h00, 1'b1);
        bus_read("R4", 'h2D, 1'b0);

        // R3: accept a character, then hold off a second one
        rx_valid = 1'b1; rx_data = 8'h5A;
        addr = 8'h25; step("R3");
        rx_data = 8'hC3;
        addr = 8'h26; step("R3");
        addr = 8'h2D; step("R3");
        // R6: status writes keep the receive-ready bits
        bus_write("R6", 'h25, 'hFFFF);
        bus_write("R6", 'h26, 'hFFFF);
        // R8: receive-side interrupt
        bus_write("R8", 'h20, 'h0200);
        bus_read("R8", 'h25, 1'b0);
        // R4: consuming read, then a repeated read shows no valid bit
        rx_valid = 1'b0;
        bus_read("R4", 'h00, 1'b1);
        bus_read("R4", 'h00, 1'b1);
        bus_read("R4", 'h25, 1'b0);
        // R3: next character taken once free
        rx_valid = 1'b1; rx_data = 8'hC3;
        addr = 8'h00; step("R3");
        rx_valid = 1'b0;
        bus_read("R4", 'h00, 1'b1);

        // R5: break marker
        rx_valid = 1'b1; rx_brk = 1'b1; rx_data = 8'h77;
        addr = 8'h00; step("R5");
        rx_valid = 1'b0; rx_brk = 1'b0;
        bus_read("R5", 'h00, 1'b0);
        bus_read("R5", 'h00, 1'b1);

        // R8: transmit-side needs both enables
        bus_write("R8", 'h20, 'h2000);
        bus_read("R8", 'h20, 1'b0);
        bus_write("R8", 'h20, 'h0040);
        bus_read("R8", 'h20, 1'b0);
        bus_write("R8", 'h20, 'h2040);
        bus_read("R8", 'h20, 1'b0);
        bus_write("R8", 'h20, 'h0000);

        // R7: transmit dropped while disabled, sent when enabled
        bus_write("R7", 'h10, 'h0142);
        bus_read("R7", 'h21, 1'b0);
        bus_write("R7", 'h21, 'h0005);
        bus_write("R7", 'h10, 'h01A5);
        bus_read("R7", 'h21, 1'b0);
        bus_write("R7", 'h10, 'h003C);
        bus_write("R7", 'h10, 'h00E1);
        bus_read("R7", 'h21, 1'b0);
        bus_read("R7", 'h21, 1'b0);

        // R9: soft reset with populated state
        bus_write("R9", 'h20, 'h2241);
        bus_write("R9", 'h22, 'h0123);
        bus_write("R9", 'h2A, 'h5555);
        bus_write("R9", 'h2B, 'h00AA);
        bus_write("R9", 'h24, 'h0801);
        bus_write("R9", 'h2C, 'h0064);
        rx_valid = 1'b1; rx_data = 8'h9E;
        addr = 8'h00; step("R9");
        rx_valid = 1'b0;
        bus_write("R9", 'h21, 'h0006);
        sweep("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule